// File: doc/BRIEF.md
# Configurable Serial Audio Frame Transmitter

This block turns one left-channel and one right-channel sample per frame into a serial data stream. It drives a word-select line and a serial data line against an externally supplied bit clock. The bit clock is sampled in the block's own system clock domain. Every bit-clock edge of the selected kind advances a frame position counter. The frame length is a configuration input.

Each channel's sample field can start at any frame position. It can be cut short at a chosen low sample bit and sent in either bit order. Samples are 16 or 32 bits wide. Frame positions that neither field covers carry zero, which lets a wide converter take narrower samples. A field that runs past the end of the frame is cut off there.

A producer offers sample pairs through a valid/ready handshake. Ready is a single-cycle pulse at each frame boundary. Samples and configuration are captured only at that boundary. When no pair is offered at the boundary, the previous pair is sent again and an underrun pulse is raised.

Top module: `audtx_serializer`

## Requirements
- R1: Frame positions count from 0 to the frame length minus 1 and then wrap to 0. WS is low for positions below half the frame length and high for the rest. The first position sent after WS falls is position 0.
- R2: With the edge control at 0, SD and WS change only after falling bit-clock edges, so they are stable at rising edges where the receiver samples. With the control at 1, the roles of the two edges are swapped.
- R3: In MSB-first order (order control 0), a channel's start position carries the sample's top bit. Each following position carries the next lower sample bit, down to and including the low-bit setting.
- R4: In LSB-first order (order control 1), the start position carries the sample bit at the low-bit setting. Each following position carries the next higher sample bit, up to and including the top bit.
- R5: With the width control at 0, only sample bits 15..0 are used, the top bit is 15 and only the low 4 bits of the low-bit setting count. With the width control at 1, bits 31..0 are used and the top bit is 31.
- R6: Every frame position outside both channel fields is sent as 0.
- R7: Field bits that fall beyond the last frame position are dropped and never appear in a later frame.
- R8: Where the left and right fields overlap, the left field's bit is sent.
- R9: Ready pulses for one clock at each frame boundary. Samples and all configuration inputs are captured only at that boundary, so changes made during a frame do not affect that frame.
- R10: If valid is low at a frame boundary, the previous sample pair is sent again and underrun is high for exactly one clock. When valid is high at the boundary, underrun stays low.
- R11: After reset, SD is 0, WS is 1, underrun is 0 and ready is 0 until the first launching bit-clock edge. That edge starts a frame at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial bit clock, synchronous to clk and at most a quarter of its rate |
| cfg_frame_len | input | LW (7) | Frame length in bits, 2 to FRAME_MAX |
| cfg_left_start | input | PW (6) | Frame position where the left field starts |
| cfg_right_start | input | PW (6) | Frame position where the right field starts |
| cfg_low_bit | input | SSW (5) | Lowest sample bit that is sent |
| cfg_lsb_first | input | 1 | 0 sends MSB first, 1 sends LSB first |
| cfg_wide | input | 1 | 0 selects 16-bit samples, 1 selects 32-bit samples |
| cfg_launch_rise | input | 1 | 0 changes data on the falling edge, 1 on the rising edge |
| smp_valid | input | 1 | A sample pair is offered |
| smp_ready | output | 1 | One-clock pulse at a frame boundary that takes the offered pair |
| smp_left | input | SAMPLE_W (32) | Left-channel sample |
| smp_right | input | SAMPLE_W (32) | Right-channel sample |
| sd | output | 1 | Serial data |
| ws | output | 1 | Word select, low for the left half of the frame |
| underrun | output | 1 | One-clock pulse when a boundary passes with no new pair |

## Verification
A wrong position count shows up at the ports within one frame: WS flips at the wrong position and the next frame's bit 0 is misplaced. A wrong field offset or bit index corrupts the captured frame at the exact position where it occurs. State captured at the wrong time can only be seen one frame later. For that reason the bench changes configuration in the middle of a frame, and checks repeated frames after an underrun for leftover data in the leading zero positions.

// File: rtl/audtx_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the serial audio frame transmitter.
package audtx_pkg;

    // Order in which the bits of a sample field are sent.
    typedef enum logic {
        ORDER_MSB_FIRST = 1'b0,
        ORDER_LSB_FIRST = 1'b1
    } bit_order_e;

    // Bit-clock edge on which SD and WS are launched.
    typedef enum logic {
        LAUNCH_ON_FALL = 1'b0,
        LAUNCH_ON_RISE = 1'b1
    } launch_edge_e;

    // Word-select level for a frame position: high in the second half.
    function automatic logic ws_level(input int unsigned pos, input int unsigned len);
        return pos >= (len / 2);
    endfunction

endpackage

// File: rtl/audtx_sck_edge.sv
`timescale 1ns/1ps
// Detects the launching edge of the bit clock in the system clock domain.
// Assumes sck is synchronous to clk and changes at most every second clk.
module audtx_sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic launch_rise,
    output logic launch
);
    import audtx_pkg::*;

    logic sck_q;

    // Keep the previous bit-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    // Flag the edge kind selected by the launch control.
    always_comb begin
        if (launch_rise == LAUNCH_ON_RISE) launch = sck & ~sck_q;
        else                               launch = ~sck & sck_q;
    end

endmodule

// File: rtl/audtx_field_pick.sv
`timescale 1ns/1ps
// Decides whether a frame position falls inside one channel's field and,
// if so, which sample bit it carries. Purely combinational.
// Assumes SAMPLE_W is a power of two, so masking the low-bit setting with
// the top bit index keeps it inside the active sample width.
module audtx_field_pick #(
    parameter int SAMPLE_W = 32,
    parameter int PW       = 6,
    parameter int SSW      = 5
) (
    input  logic [PW-1:0]       pos,
    input  logic [PW-1:0]       start,
    input  logic [SSW-1:0]      low_bit,
    input  logic                order_lsb,
    input  logic                wide,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                hit,
    output logic                bit_o
);
    import audtx_pkg::*;

    localparam int IW = ((PW > SSW) ? PW : SSW) + 1;
    localparam logic [IW-1:0] TOP_WIDE   = IW'(SAMPLE_W - 1);
    localparam logic [IW-1:0] TOP_NARROW = IW'(SAMPLE_W / 2 - 1);

    logic [IW-1:0] top_idx, low_idx, pos_x, start_x, offset, span, idx;

    // Map a frame position to a sample bit index and select that bit.
    always_comb begin
        top_idx = wide ? TOP_WIDE : TOP_NARROW;
        low_idx = IW'(low_bit) & top_idx;
        pos_x   = IW'(pos);
        start_x = IW'(start);
        offset  = pos_x - start_x;
        span    = top_idx - low_idx;
        hit     = (pos_x >= start_x) && (offset <= span);
        idx     = (order_lsb == ORDER_LSB_FIRST) ? (low_idx + offset) : (top_idx - offset);
        bit_o   = hit && (|(sample & (SAMPLE_W'(1) << idx)));
    end

    // Inside a field the chosen bit lies within the active sample width.
    always_comb begin
        if (hit) begin
            a_idx_in_width_r5: assert (idx <= top_idx)
                else $error("field index beyond the sample top bit");
        end
    end

endmodule

// File: rtl/audtx_frame_ctl.sv
`timescale 1ns/1ps
// Frame position counter plus the captured samples and configuration.
// The next position and the settings in force for it are output so the
// top level can register SD and WS on the same launch.
// Assumes cfg_frame_len lies between 2 and 2**PW.
module audtx_frame_ctl #(
    parameter int SAMPLE_W = 32,
    parameter int PW       = 6,
    parameter int SSW      = 5,
    parameter int LW       = PW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic [LW-1:0]       cfg_frame_len,
    input  logic [PW-1:0]       cfg_left_start,
    input  logic [PW-1:0]       cfg_right_start,
    input  logic [SSW-1:0]      cfg_low_bit,
    input  logic                cfg_lsb_first,
    input  logic                cfg_wide,
    input  logic                cfg_launch_rise,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                smp_ready,
    output logic                launch_rise_cur,
    output logic [PW-1:0]       pos_nxt,
    output logic [LW-1:0]       eff_len,
    output logic [PW-1:0]       eff_lstart,
    output logic [PW-1:0]       eff_rstart,
    output logic [SSW-1:0]      eff_low,
    output logic                eff_lsb,
    output logic                eff_wide,
    output logic [SAMPLE_W-1:0] eff_left,
    output logic [SAMPLE_W-1:0] eff_right,
    output logic                underrun
);
    logic                first_q;
    logic [PW-1:0]       pos_q;
    logic [LW-1:0]       len_q;
    logic [PW-1:0]       lstart_q, rstart_q;
    logic [SSW-1:0]      low_q;
    logic                lsb_q, wide_q, rise_q;
    logic [SAMPLE_W-1:0] left_q, right_q;
    logic                underrun_q;
    logic                boundary, take;

    // A boundary is the launch that ends the last position, or the first launch.
    always_comb begin
        boundary = launch && (first_q || (LW'(pos_q) == len_q - LW'(1)));
        take     = boundary && smp_valid;
    end

    // Settings for the next position: fresh inputs at a boundary, held otherwise.
    always_comb begin
        pos_nxt         = boundary ? '0 : pos_q + PW'(1);
        eff_len         = boundary ? cfg_frame_len   : len_q;
        eff_lstart      = boundary ? cfg_left_start  : lstart_q;
        eff_rstart      = boundary ? cfg_right_start : rstart_q;
        eff_low         = boundary ? cfg_low_bit     : low_q;
        eff_lsb         = boundary ? cfg_lsb_first   : lsb_q;
        eff_wide        = boundary ? cfg_wide        : wide_q;
        eff_left        = take ? smp_left  : left_q;
        eff_right       = take ? smp_right : right_q;
        launch_rise_cur = first_q ? cfg_launch_rise : rise_q;
    end

    // Advance the position and capture the frame's settings at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q    <= 1'b1;
            pos_q      <= '0;
            len_q      <= LW'(2 ** PW);
            lstart_q   <= '0;
            rstart_q   <= '0;
            low_q      <= '0;
            lsb_q      <= 1'b0;
            wide_q     <= 1'b0;
            rise_q     <= 1'b0;
            left_q     <= '0;
            right_q    <= '0;
            underrun_q <= 1'b0;
        end else begin
            underrun_q <= boundary && !smp_valid;
            if (launch) begin
                first_q <= 1'b0;
                pos_q   <= pos_nxt;
            end
            if (boundary) begin
                len_q    <= cfg_frame_len;
                lstart_q <= cfg_left_start;
                rstart_q <= cfg_right_start;
                low_q    <= cfg_low_bit;
                lsb_q    <= cfg_lsb_first;
                wide_q   <= cfg_wide;
                rise_q   <= cfg_launch_rise;
            end
            if (take) begin
                left_q  <= smp_left;
                right_q <= smp_right;
            end
        end
    end

    assign smp_ready = boundary;
    assign underrun  = underrun_q;

    // R1: once running, the position stays below the captured frame length.
    p_pos_in_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !first_q |-> (LW'(pos_q) < len_q));

    // R1: a launch that is not a boundary steps the position by one.
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(launch) && !$past(smp_ready)) |-> (pos_q == $past(pos_q) + PW'(1)));

    // R9: ready is a single-clock pulse.
    p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |=> !smp_ready);

    // R9: captured settings and samples change only right after a boundary.
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(smp_ready)) |->
            ($stable(len_q) && $stable(lstart_q) && $stable(low_q) && $stable(left_q)));

    // R10: underrun lasts one clock.
    p_underrun_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);

endmodule

// File: rtl/audtx_serializer.sv
`timescale 1ns/1ps
// Top level of the serial audio frame transmitter. Sends one left and one
// right sample per frame on sd, with ws marking the halves, against an
// external bit clock sampled in the clk domain.
// Assumes sck is synchronous to clk, at most a quarter of its rate.
module audtx_serializer #(
    parameter int SAMPLE_W  = 32,
    parameter int FRAME_MAX = 64,
    parameter int PW        = $clog2(FRAME_MAX),
    parameter int LW        = PW + 1,
    parameter int SSW       = $clog2(SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sck,
    input  logic [LW-1:0]       cfg_frame_len,
    input  logic [PW-1:0]       cfg_left_start,
    input  logic [PW-1:0]       cfg_right_start,
    input  logic [SSW-1:0]      cfg_low_bit,
    input  logic                cfg_lsb_first,
    input  logic                cfg_wide,
    input  logic                cfg_launch_rise,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                sd,
    output logic                ws,
    output logic                underrun
);
    import audtx_pkg::*;

    logic                launch, launch_rise_cur;
    logic [PW-1:0]       pos_nxt, eff_lstart, eff_rstart;
    logic [LW-1:0]       eff_len;
    logic [SSW-1:0]      eff_low;
    logic                eff_lsb, eff_wide;
    logic [SAMPLE_W-1:0] eff_left, eff_right;
    logic                l_hit, l_bit, r_hit, r_bit;
    logic                sd_q, ws_q;

    audtx_sck_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck         (sck),
        .launch_rise (launch_rise_cur),
        .launch      (launch)
    );

    audtx_frame_ctl #(.SAMPLE_W(SAMPLE_W), .PW(PW), .SSW(SSW), .LW(LW)) u_ctl (
        .clk             (clk),
        .rst_n           (rst_n),
        .launch          (launch),
        .cfg_frame_len   (cfg_frame_len),
        .cfg_left_start  (cfg_left_start),
        .cfg_right_start (cfg_right_start),
        .cfg_low_bit     (cfg_low_bit),
        .cfg_lsb_first   (cfg_lsb_first),
        .cfg_wide        (cfg_wide),
        .cfg_launch_rise (cfg_launch_rise),
        .smp_valid       (smp_valid),
        .smp_left        (smp_left),
        .smp_right       (smp_right),
        .smp_ready       (smp_ready),
        .launch_rise_cur (launch_rise_cur),
        .pos_nxt         (pos_nxt),
        .eff_len         (eff_len),
        .eff_lstart      (eff_lstart),
        .eff_rstart      (eff_rstart),
        .eff_low         (eff_low),
        .eff_lsb         (eff_lsb),
        .eff_wide        (eff_wide),
        .eff_left        (eff_left),
        .eff_right       (eff_right),
        .underrun        (underrun)
    );

    audtx_field_pick #(.SAMPLE_W(SAMPLE_W), .PW(PW), .SSW(SSW)) u_left (
        .pos       (pos_nxt),
        .start     (eff_lstart),
        .low_bit   (eff_low),
        .order_lsb (eff_lsb),
        .wide      (eff_wide),
        .sample    (eff_left),
        .hit       (l_hit),
        .bit_o     (l_bit)
    );

    audtx_field_pick #(.SAMPLE_W(SAMPLE_W), .PW(PW), .SSW(SSW)) u_right (
        .pos       (pos_nxt),
        .start     (eff_rstart),
        .low_bit   (eff_low),
        .order_lsb (eff_lsb),
        .wide      (eff_wide),
        .sample    (eff_right),
        .hit       (r_hit),
        .bit_o     (r_bit)
    );

    // Launch the next serial bit and word-select level; left wins on overlap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_q <= 1'b0;
            ws_q <= 1'b1;
        end else if (launch) begin
            sd_q <= l_hit ? l_bit : (r_hit & r_bit);
            ws_q <= ws_level(int'(pos_nxt), int'(eff_len));
        end
    end

    assign sd = sd_q;
    assign ws = ws_q;

    // R2: the serial lines only move on a launching edge.
    p_outputs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(launch)) |-> ($stable(sd) && $stable(ws)));

    // R1: the launch that starts a frame drives WS low for position 0.
    p_bit0_ws_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(smp_ready)) |-> !ws);

endmodule

// File: tb/audtx_serializer_test.sv
`timescale 1ns/1ps
module audtx_serializer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic [6:0]  cfg_len = 7'd32;
    logic [5:0]  cfg_lpos = '0, cfg_rpos = 6'd16;
    logic [4:0]  cfg_ss = '0;
    logic        cfg_lsb = 1'b0, cfg_wide = 1'b0, cfg_edge = 1'b0;
    logic        s_valid = 1'b0;
    logic [31:0] s_left = '0, s_right = '0;
    logic        s_ready, sd, ws, underrun;

    int n_tests = 0, n_fail = 0;
    bit run_sck = 1'b0;
    bit done = 1'b0;
    int frames_done = 0, ucount = 0, idx = 200;
    logic prev_ws = 1'b1;
    logic [127:0] fbits, fws, last_bits, last_ws;

    always #10 clk = ~clk;

    audtx_serializer uut (
        .clk(clk), .rst_n(rst_n), .sck(sck),
        .cfg_frame_len(cfg_len), .cfg_left_start(cfg_lpos), .cfg_right_start(cfg_rpos),
        .cfg_low_bit(cfg_ss), .cfg_lsb_first(cfg_lsb), .cfg_wide(cfg_wide),
        .cfg_launch_rise(cfg_edge), .smp_valid(s_valid), .smp_ready(s_ready),
        .smp_left(s_left), .smp_right(s_right), .sd(sd), .ws(ws), .underrun(underrun)
    );

    // Bit clock: toggles every two clk, capturing SD/WS just before each capture edge.
    always begin
        @(negedge clk);
        @(negedge clk);
        if (!run_sck) begin
            sck = 1'b0; prev_ws = 1'b1; idx = 200;
        end else begin
            if ((cfg_edge == 1'b0) ? (sck == 1'b0) : (sck == 1'b1)) begin
                if (prev_ws && !ws) idx = 0;
                if (idx < 128) begin fbits[idx] = sd; fws[idx] = ws; end
                idx++;
                if (idx == int'(cfg_len)) begin
                    last_bits = fbits; last_ws = fws; frames_done++;
                end
                prev_ws = ws;
            end
            sck = ~sck;
        end
    end

    // Count underrun pulses (one clock wide, so one negedge each).
    always @(negedge clk) if (rst_n && underrun) ucount++;

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] model(int len, int lpos, int rpos, int ss, bit lsb,
                                           bit wide, logic [31:0] l, logic [31:0] r);
        logic [127:0] f = '0;
        int top = wide ? 31 : 15;
        int lo = wide ? ss : (ss % 16);
        for (int p = 0; p < len; p++) begin
            int kl = p - lpos;
            int kr = p - rpos;
            if (kl >= 0 && kl <= top - lo)
                f[p] = l[lsb ? lo + kl : top - kl];
            else if (kr >= 0 && kr <= top - lo)
                f[p] = r[lsb ? lo + kr : top - kr];
        end
        return f;
    endfunction

    function automatic logic [127:0] mask(int len);
        logic [127:0] m = '0;
        for (int p = 0; p < len; p++) m[p] = 1'b1;
        return m;
    endfunction

    function automatic logic [127:0] ws_model(int len);
        logic [127:0] w = '0;
        for (int p = 0; p < len; p++) w[p] = (p >= len / 2);
        return w;
    endfunction

    task automatic do_reset(bit edge_sel);
        run_sck = 1'b0;
        s_valid = 1'b0;
        cfg_edge = edge_sel;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        // R11: idle outputs after reset.
        chk("R11 sd", 128'(sd), 128'(0));
        chk("R11 ws", 128'(ws), 128'(1));
        chk("R11 underrun", 128'(underrun), 128'(0));
        chk("R11 ready", 128'(s_ready), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        run_sck = 1'b1;
    endtask

    task automatic run_case(string req, int len, int lpos, int rpos, int ss, bit lsb, bit wide,
                            logic [31:0] l, logic [31:0] r, bit disturb);
        int n, u0;
        logic [127:0] m;
        cfg_len = 7'(len); cfg_lpos = 6'(lpos); cfg_rpos = 6'(rpos); cfg_ss = 5'(ss);
        cfg_lsb = lsb; cfg_wide = wide;
        s_left = l; s_right = r; s_valid = 1'b1;
        u0 = ucount;
        forever begin
            @(negedge clk); #1;
            if (s_ready) break;
        end
        n = frames_done;
        @(negedge clk);
        s_valid = 1'b0;
        if (disturb) begin
            repeat (20) @(negedge clk);
            cfg_lpos = 6'(lpos + 3); cfg_lsb = ~lsb; cfg_ss = 5'(ss + 2); s_left = ~l;
        end
        while (frames_done < n + 1) @(negedge clk);
        m = mask(len);
        chk({req, " frame bits"}, last_bits & m, model(len, lpos, rpos, ss, lsb, wide, l, r));
        chk("R1 ws pattern", last_ws & m, ws_model(len));
        chk("R10 no underrun when valid", 128'(ucount - u0), 128'(0));
    endtask

    task automatic run_underrun(int len, int lpos, int rpos, int ss, bit lsb, bit wide,
                                logic [31:0] l, logic [31:0] r);
        int n = frames_done;
        int u0 = ucount;
        while (frames_done < n + 1) @(negedge clk);
        chk("R10 R7 repeated frame", last_bits & mask(len),
            model(len, lpos, rpos, ss, lsb, wide, l, r));
        chk("R10 underrun pulses", 128'(ucount - u0), 128'(1));
    endtask

    initial begin
        do_reset(1'b0);
        // R3, R5: 16-bit MSB first, upper sample half ignored.
        run_case("R3 R5 msb16", 32, 0, 16, 0, 1'b0, 1'b0, 32'h1234A5C3, 32'hFFFF0F0F, 1'b0);
        // R4: LSB first with a raised low bit.
        run_case("R4 lsb16", 32, 2, 18, 4, 1'b1, 1'b0, 32'h0000B38E, 32'h00006D21, 1'b0);
        // R5: 32-bit samples in a 64-bit frame.
        run_case("R5 msb32", 64, 0, 32, 8, 1'b0, 1'b1, 32'hC0FFEE11, 32'h8BADF00D, 1'b0);
        // R5: narrow mode uses only the low 4 bits of the low-bit setting.
        run_case("R5 low bit masked", 32, 1, 17, 19, 1'b0, 1'b0, 32'h00009A5F, 32'h0000F00F, 1'b0);
        // R6: gaps in a 48-bit frame are zero.
        run_case("R6 zero fill", 48, 4, 28, 0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0);
        // R7, R8: left runs off the frame end and covers the right start.
        run_case("R7 R8 truncate overlap", 32, 20, 24, 0, 1'b0, 1'b1, 32'hDEADBEEF, 32'hFFFFFFFF, 1'b0);
        // R10, R7: no new pair, frame repeats with leading zeros intact.
        run_underrun(32, 20, 24, 0, 1'b0, 1'b1, 32'hDEADBEEF, 32'hFFFFFFFF);
        // R8: LSB-first overlap.
        run_case("R8 lsb overlap", 32, 8, 12, 0, 1'b1, 1'b0, 32'h00005555, 32'h0000FFFF, 1'b0);
        // R9: mid-frame changes do not reach the current frame.
        run_case("R9 frozen settings", 32, 3, 19, 1, 1'b0, 1'b0, 32'h00007E81, 32'h000013C6, 1'b1);
        // R2: swapped edges after a fresh reset.
        do_reset(1'b1);
        run_case("R2 R11 rise launch", 32, 0, 16, 0, 1'b0, 1'b0, 32'h0000A5C3, 32'h00003C5A, 1'b0);
        run_case("R2 rise launch lsb", 40, 5, 24, 2, 1'b1, 1'b0, 32'h0000F1E2, 32'h00000FF0, 1'b0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #3_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule